// File: doc/BRIEF.md
# Serial Channel Error and State Register

This block holds the read-only status word of one serial channel that can run asynchronous (UART), clocked-serial (CSI) or I2C transfers. The channel's receiver, transmitter and the CPU bus logic feed it single-cycle event pulses. It turns those pulses into three sticky error flags and two live state bits, and presents them together as a 16-bit word.

The three error flags are:
- **Framing.** Set when a UART word ends without a valid stop bit.
- **Parity.** Set when the UART parity check fails. In I2C transmit mode it is also set when the slave leaves the ACK slot unacknowledged.
- **Overrun.** Set when unread receive data is overwritten, or when a CSI slave transfer starts before any transmit data was supplied.

Software clears an error flag only through a separate write-one-to-clear strobe. A parameter builds a lean instance in which the error flags do not exist.

Top module: `serch_status`

## Requirements
- R1: After reset `status_o` is 0000h. Bits 15:7, 4 and 3 always read 0.
- R2: A `rx_done_i` pulse with `stop_ok_i`=0 while `mode_i`=0 (UART) sets bit 2 (framing) one cycle later. The same pulse in any other mode leaves bit 2 unchanged.
- R3: A `rx_done_i` pulse with `parity_ok_i`=0 in UART mode sets bit 1 (parity) one cycle later.
- R4: In I2C mode (`mode_i`=2) with `i2c_tx_i`=1, an `ack_slot_i` pulse with `ack_seen_i`=0 sets bit 1. With `ack_seen_i`=1, or with `i2c_tx_i`=0, bit 1 is not set.
- R5: Bit 0 (overrun) is set when `rx_done_i` or `cpu_wr_i` pulses while received data is still unread. Received data counts as unread from a `rx_done_i` until the next `cpu_rd_i` or `cpu_wr_i`.
- R6: In CSI mode (`mode_i`=1) with `csi_slave_i`=1, a `slave_start_i` pulse while bit 5 is 0 sets bit 0. If bit 5 is 1, or `csi_slave_i` is 0, bit 0 is not set.
- R7: Each error flag stays set until a `clr_wr_i` pulse carries a 1 in its own `clr_data_i` bit (bit 2 framing, bit 1 parity, bit 0 overrun). A 0 in that bit leaves the flag unchanged.
- R8: When a set event and a clear of the same flag occur in the same cycle, the flag ends up set.
- R9: Bit 5 (buffer full) is set by `cpu_wr_i` or `rx_done_i` and cleared by `shift_load_i` or `cpu_rd_i`. If a set and a clear arrive together, the set wins.
- R10: Bit 6 (transfer busy) equals `busy_i` delayed by one cycle.
- R11: With `HAS_ERR`=0, bits 2:0 always read 0, whatever the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Channel mode: 0 UART, 1 CSI, 2 I2C |
| i2c_tx_i | input | 1 | I2C channel is transmitting |
| csi_slave_i | input | 1 | CSI channel is a slave |
| rx_done_i | input | 1 | Reception complete pulse |
| stop_ok_i | input | 1 | Valid stop bit seen, qualified by rx_done_i |
| parity_ok_i | input | 1 | Parity matched, qualified by rx_done_i |
| ack_slot_i | input | 1 | I2C ACK time slot pulse |
| ack_seen_i | input | 1 | ACK present, qualified by ack_slot_i |
| cpu_wr_i | input | 1 | CPU wrote the data buffer |
| cpu_rd_i | input | 1 | CPU read the data buffer |
| shift_load_i | input | 1 | Shifter took the buffer contents |
| slave_start_i | input | 1 | CSI slave transfer begins |
| busy_i | input | 1 | Shifter active |
| clr_wr_i | input | 1 | Clear-register write strobe |
| clr_data_i | input | 3 | Write-one-to-clear data for the three error flags |
| status_o | output | 16 | Status word |

## Verification
Every result is registered. An event pulse presented in one cycle therefore shows in `status_o` after the next rising edge, and `busy_i` appears in bit 6 one cycle late. The bench drives each pulse on a falling edge and removes it on the following falling edge. It reads `status_o` at that second falling edge, by which time exactly one rising edge has passed. Each scenario starts from a fresh reset, so the unread-data and buffer-full state always have known values. A second instance built without error flags gets the same stimulus and is checked alongside the first.

// File: rtl/serch_status.sv
module serch_status #(
  parameter bit HAS_ERR = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_i,
  input  logic        i2c_tx_i,
  input  logic        csi_slave_i,
  input  logic        rx_done_i,
  input  logic        stop_ok_i,
  input  logic        parity_ok_i,
  input  logic        ack_slot_i,
  input  logic        ack_seen_i,
  input  logic        cpu_wr_i,
  input  logic        cpu_rd_i,
  input  logic        shift_load_i,
  input  logic        slave_start_i,
  input  logic        busy_i,
  input  logic        clr_wr_i,
  input  logic [2:0]  clr_data_i,
  output logic [15:0] status_o
);
  localparam logic [1:0] M_UART = 2'd0;
  localparam logic [1:0] M_CSI  = 2'd1;
  localparam logic [1:0] M_I2C  = 2'd2;

  logic tsf, bff, unread;
  logic fef, pef, ovf;

  wire fe_set = rx_done_i && mode_i == M_UART && !stop_ok_i;
  wire pe_set = (rx_done_i && mode_i == M_UART && !parity_ok_i) ||
                (ack_slot_i && mode_i == M_I2C && i2c_tx_i && !ack_seen_i);
  wire ov_set = ((rx_done_i || cpu_wr_i) && unread) ||
                (slave_start_i && mode_i == M_CSI && csi_slave_i && !bff);
  wire [2:0] clr = clr_wr_i ? clr_data_i : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsf    <= 1'b0;
      bff    <= 1'b0;
      unread <= 1'b0;
    end else begin
      tsf    <= busy_i;
      bff    <= cpu_wr_i || rx_done_i || (bff && !shift_load_i && !cpu_rd_i);
      unread <= rx_done_i || (unread && !cpu_rd_i && !cpu_wr_i);
    end
  end

  generate
    if (HAS_ERR) begin : g_err
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          fef <= 1'b0;
          pef <= 1'b0;
          ovf <= 1'b0;
        end else begin
          fef <= fe_set || (fef && !clr[2]);
          pef <= pe_set || (pef && !clr[1]);
          ovf <= ov_set || (ovf && !clr[0]);
        end
      end

      p_frame_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && mode_i == M_UART && !stop_ok_i) |=> status_o[2]);
      p_frame_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[2] && mode_i != M_UART) |=> !status_o[2]);
      p_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_slot_i && mode_i == M_I2C && i2c_tx_i && !ack_seen_i) |=> status_o[1]);
      p_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_start_i && mode_i == M_CSI && csi_slave_i && !status_o[5]) |=> status_o[0]);
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2] && !(clr_wr_i && clr_data_i[2])) |=> status_o[2]);
      p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && mode_i == M_UART && !parity_ok_i && clr_wr_i && clr_data_i[1]) |=> status_o[1]);
    end else begin : g_noerr
      assign fef = 1'b0;
      assign pef = 1'b0;
      assign ovf = 1'b0;

      p_noerr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[2:0] == 3'b000);
    end
  endgenerate

  assign status_o = {9'b0, tsf, bff, 2'b00, fef, pef, ovf};

  p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[15:7] == 9'b0 && status_o[4:3] == 2'b00);
  p_bff_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_i || rx_done_i) |=> status_o[5]);
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status_o[6] == $past(busy_i));
endmodule

// File: tb/sim_serch_status.sv
`timescale 1ns/1ps
module sim_serch_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic i2c_tx_i = 0, csi_slave_i = 0, rx_done_i = 0, stop_ok_i = 1, parity_ok_i = 1;
  logic ack_slot_i = 0, ack_seen_i = 1, cpu_wr_i = 0, cpu_rd_i = 0, shift_load_i = 0;
  logic slave_start_i = 0, busy_i = 0, clr_wr_i = 0;
  logic [2:0] clr_data_i = 3'b000;
  logic [15:0] st0, st1;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  serch_status #(.HAS_ERR(1'b1)) u0 (.clk, .rst_n, .mode_i, .i2c_tx_i, .csi_slave_i,
    .rx_done_i, .stop_ok_i, .parity_ok_i, .ack_slot_i, .ack_seen_i, .cpu_wr_i, .cpu_rd_i,
    .shift_load_i, .slave_start_i, .busy_i, .clr_wr_i, .clr_data_i, .status_o(st0));
  serch_status #(.HAS_ERR(1'b0)) u1 (.clk, .rst_n, .mode_i, .i2c_tx_i, .csi_slave_i,
    .rx_done_i, .stop_ok_i, .parity_ok_i, .ack_slot_i, .ack_seen_i, .cpu_wr_i, .cpu_rd_i,
    .shift_load_i, .slave_start_i, .busy_i, .clr_wr_i, .clr_data_i, .status_o(st1));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    rx_done_i = 0; ack_slot_i = 0; cpu_wr_i = 0; cpu_rd_i = 0;
    shift_load_i = 0; slave_start_i = 0; clr_wr_i = 0; clr_data_i = 3'b000;
    stop_ok_i = 1; parity_ok_i = 1; ack_seen_i = 1;
  endtask

  task automatic do_reset();
    rst_n = 0; mode_i = 2'd0; i2c_tx_i = 0; csi_slave_i = 0; busy_i = 0;
    step(); step();
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset u0", st0, 16'h0000);
    chk("R1 reset u1", st1, 16'h0000);
  endtask

  task automatic t_frame();
    do_reset();
    rx_done_i = 1; stop_ok_i = 0; step();
    chk("R2 framing set", st0, 16'h0024);
    chk("R11 no-error instance", st1, 16'h0020);
    do_reset(); mode_i = 2'd1;
    rx_done_i = 1; stop_ok_i = 0; step();
    chk("R2 framing ignored in CSI", st0, 16'h0020);
  endtask

  task automatic t_parity();
    do_reset();
    rx_done_i = 1; parity_ok_i = 0; step();
    chk("R3 parity set", st0, 16'h0022);
    chk("R11 parity absent", st1, 16'h0020);
  endtask

  task automatic t_ack();
    do_reset(); mode_i = 2'd2; i2c_tx_i = 1;
    ack_slot_i = 1; ack_seen_i = 1; step();
    chk("R4 ack present", st0, 16'h0000);
    ack_slot_i = 1; ack_seen_i = 0; step();
    chk("R4 ack missing", st0, 16'h0002);
    do_reset(); mode_i = 2'd2; i2c_tx_i = 0;
    ack_slot_i = 1; ack_seen_i = 0; step();
    chk("R4 receive mode ignores ack", st0, 16'h0000);
  endtask

  task automatic t_overrun();
    do_reset();
    rx_done_i = 1; step();
    chk("R5 first word", st0, 16'h0020);
    rx_done_i = 1; step();
    chk("R5 rx overwrite", st0, 16'h0021);
    do_reset();
    rx_done_i = 1; step();
    cpu_rd_i = 1; step();
    chk("R9 read clears full", st0, 16'h0000);
    rx_done_i = 1; step();
    chk("R5 no overrun after read", st0, 16'h0020);
    cpu_wr_i = 1; step();
    chk("R5 write overwrite", st0, 16'h0021);
    chk("R11 overrun absent", st1, 16'h0020);
  endtask

  task automatic t_underrun();
    do_reset(); mode_i = 2'd1; csi_slave_i = 1;
    slave_start_i = 1; step();
    chk("R6 slave underrun", st0, 16'h0001);
    do_reset(); mode_i = 2'd1; csi_slave_i = 1;
    cpu_wr_i = 1; step();
    slave_start_i = 1; step();
    chk("R6 data ready no underrun", st0, 16'h0020);
    do_reset(); mode_i = 2'd1; csi_slave_i = 0;
    slave_start_i = 1; step();
    chk("R6 master ignores start", st0, 16'h0000);
  endtask

  task automatic t_clear();
    do_reset();
    rx_done_i = 1; stop_ok_i = 0; parity_ok_i = 0; step();
    chk("R7 both set", st0, 16'h0026);
    clr_wr_i = 1; clr_data_i = 3'b000; step();
    chk("R7 zero write keeps", st0, 16'h0026);
    clr_wr_i = 1; clr_data_i = 3'b010; step();
    chk("R7 clear parity only", st0, 16'h0024);
    clr_data_i = 3'b111; step();
    chk("R7 data without strobe", st0, 16'h0024);
    clr_wr_i = 1; clr_data_i = 3'b111; step();
    chk("R7 clear all", st0, 16'h0020);
  endtask

  task automatic t_setwins();
    do_reset();
    rx_done_i = 1; stop_ok_i = 0; step();
    rx_done_i = 1; stop_ok_i = 0; clr_wr_i = 1; clr_data_i = 3'b100; step();
    chk("R8 set beats clear", st0, 16'h0025);
    clr_wr_i = 1; clr_data_i = 3'b101; step();
    chk("R8 later clear works", st0, 16'h0020);
  endtask

  task automatic t_buffer();
    do_reset();
    cpu_wr_i = 1; step();
    chk("R9 write sets full", st0, 16'h0020);
    shift_load_i = 1; step();
    chk("R9 load clears full", st0, 16'h0000);
    cpu_wr_i = 1; shift_load_i = 1; step();
    chk("R9 set wins", st0, 16'h0020);
  endtask

  task automatic t_busy();
    do_reset();
    busy_i = 1; step();
    chk("R10 busy high", st0, 16'h0040);
    busy_i = 0; step();
    chk("R10 busy low", st0, 16'h0000);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_frame();
    t_parity();
    t_ack();
    t_overrun();
    t_underrun();
    t_clear();
    t_setwins();
    t_buffer();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule